// File: doc/BRIEF.md
# Interrupt enable and halt controller

This block holds the interrupt master enable of a small CPU core and its low-power halt state. The decoder reports, at the end of each instruction, a completion strobe together with one of four operation flags: enable interrupts, disable interrupts, return from interrupt handler, and halt. The block also watches the interrupt enable mask and the interrupt flag register. From these it drives the master enable, a halted level, a request to enter the interrupt handler, and a hold signal that stops the program counter from advancing on the next fetch.

The enable operation takes effect one instruction late: the master enable rises only after the instruction that follows it has completed. The return operation sets the enable without that delay. Halt has three outcomes. With the enable set, the core sleeps until an interrupt is pending and then the handler is requested. With the enable clear and nothing pending, the core sleeps until something is pending and then resumes without a handler. With the enable clear and something already pending, the core does not sleep at all. Instead the next fetch fails to advance the program counter, so the following byte is read twice.

Top module: `irq_halt_ctrl`

## Requirements
- R1: After reset, ime, halted, pc_hold and take_irq are all 0 and no delayed enable is waiting.
- R2: When insn_done is high with op_disable, ime is 0 from the next cycle and take_irq stays 0 in that cycle, even with an interrupt pending.
- R3: With ENABLE_DELAY = 1, ime stays 0 in the cycle after insn_done with op_enable and becomes 1 in the cycle after the next insn_done.
- R4: An insn_done with op_disable while an enable is still delayed cancels it, so ime stays 0 after later instructions complete.
- R5: When insn_done is high with op_return, ime is 1 from the next cycle.
- R6: An interrupt is pending when irq_enable AND irq_flag is nonzero. take_irq is high combinationally when ime is 1, an interrupt is pending, and either the core is halted or insn_done is high without op_disable. ime is 0 in the cycle after take_irq.
- R7: Halt completing with ime 1 and nothing pending raises halted from the next cycle. halted holds while nothing is pending. In the first cycle that something is pending, take_irq is high, and halted and ime are 0 in the next cycle.
- R8: Halt completing with ime 0 and nothing pending raises halted. When something becomes pending, halted is 0 in the next cycle and take_irq stays 0.
- R9: Halt completing with ime 0 and something pending leaves halted at 0. pc_hold is 1 from the next cycle until the cycle after the next insn_done, when it returns to 0.
- R10: Operation flags have no effect unless insn_done is high, and insn_done has no effect while halted is 1.
- R11: Flag bits whose enable bit is 0 do not count as pending, so they neither request the handler nor wake the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Current instruction completes this cycle |
| op_enable | input | 1 | Completing instruction enables interrupts (delayed) |
| op_disable | input | 1 | Completing instruction disables interrupts |
| op_return | input | 1 | Completing instruction returns from the handler |
| op_halt | input | 1 | Completing instruction is halt |
| irq_enable | input | FLAG_W | Interrupt enable mask |
| irq_flag | input | FLAG_W | Interrupt request flags |
| ime | output | 1 | Interrupt master enable |
| halted | output | 1 | Core is in the low-power halt state |
| take_irq | output | 1 | Enter the interrupt handler at this boundary |
| pc_hold | output | 1 | Do not advance the program counter on the next fetch |

## Verification
A wrong delay count or a lost cancel shows at ime one instruction boundary after the enable: it either rises too early or stays high after a disable. A wrong halt branch shows in the cycle after the halt completes, as halted and pc_hold taking the wrong pair of values. A stale master enable shows on the wake-up cycle, as take_irq in the wrong state. Every corruption is visible at the ports within two cycles of the instruction that caused it.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

   typedef struct packed {
      logic en;
      logic dis;
      logic ret;
      logic halt;
   } irq_ops_t;

   function automatic int unsigned delay_cnt_width(input int unsigned delay);
      return (delay < 2) ? 1 : $clog2(delay + 1);
   endfunction

endpackage

// File: rtl/irq_pend_detect.sv
module irq_pend_detect #(
   parameter int unsigned FLAG_W = 5
) (
   input  logic [FLAG_W-1:0] mask_i,
   input  logic [FLAG_W-1:0] flag_i,
   output logic              pending_o
);
   logic [FLAG_W-1:0] live;

   for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
      assign live[b] = mask_i[b] & flag_i[b];
   end

   assign pending_o = |live;
endmodule

// File: rtl/irq_ime_unit.sv
module irq_ime_unit
   import irq_ctl_pkg::*;
#(
   parameter int unsigned ENABLE_DELAY = 1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     done_i,
   input  irq_ops_t ops_i,
   input  logic     take_i,
   output logic     ime_o
);
   localparam int unsigned CNT_W = delay_cnt_width(ENABLE_DELAY);

   logic ime_q, ime_d;
   logic expire;

   if (ENABLE_DELAY == 0) begin : g_nodelay
      assign expire = done_i & ops_i.en;
   end else begin : g_delay
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n)                    cnt_q <= '0;
         else if (done_i && ops_i.dis)  cnt_q <= '0;
         else if (done_i && ops_i.en)   cnt_q <= CNT_W'(ENABLE_DELAY);
         else if (done_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
      end

      assign expire = done_i && (cnt_q == CNT_W'(1));

      // R4: a disable wipes any delayed enable
      a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
         (done_i && ops_i.dis) |=> (cnt_q == 0 && !ime_q));
   end

   always_comb begin
      ime_d = ime_q;
      if (expire || (done_i && ops_i.ret)) ime_d = 1'b1;
      if (done_i && ops_i.dis)             ime_d = 1'b0;
      if (take_i)                          ime_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ime_q <= 1'b0;
      else        ime_q <= ime_d;
   end

   assign ime_o = ime_q;

   // R2: disable takes effect in the next cycle
   a_r2_dis_now: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && ops_i.dis) |=> !ime_q);
   // R5: return sets the enable without delay
   a_r5_ret_now: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && ops_i.ret && !take_i) |=> ime_q);
   // R6: servicing clears the enable
   a_r6_take_clr: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> !ime_q);
   // R10: without a completion only servicing can move the enable
   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_i && !take_i) |=> $stable(ime_q));
endmodule

// File: rtl/irq_halt_unit.sv
module irq_halt_unit
   import irq_ctl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     done_i,
   input  irq_ops_t ops_i,
   input  logic     ime_i,
   input  logic     pending_i,
   input  logic     take_i,
   output logic     halted_o,
   output logic     pc_hold_o
);
   logic halted_q, halted_d;
   logic hold_q, hold_d;

   always_comb begin
      halted_d = halted_q;
      hold_d   = hold_q;
      if (halted_q && pending_i) halted_d = 1'b0;
      if (done_i)                hold_d   = 1'b0;
      if (done_i && ops_i.halt && !take_i) begin
         if (!ime_i && pending_i) hold_d   = 1'b1;
         else                     halted_d = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
         hold_q   <= 1'b0;
      end else begin
         halted_q <= halted_d;
         hold_q   <= hold_d;
      end
   end

   assign halted_o  = halted_q;
   assign pc_hold_o = hold_q;

   // R7: sleep persists while nothing is pending
   a_r7_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_q && !pending_i) |=> halted_q);
   // R8: any pending interrupt ends the sleep
   a_r8_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_q && pending_i) |=> !halted_q);
   // R9: the repeated-fetch case never sleeps and holds until the next completion
   a_r9_bug_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && ops_i.halt && !ime_i && pending_i) |=> (pc_hold_o && !halted_q));
   a_r9_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !done_i) |=> hold_q);
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(hold_q && halted_q));
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
   import irq_ctl_pkg::*;
#(
   parameter int unsigned FLAG_W       = 5,
   parameter int unsigned ENABLE_DELAY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_done,
   input  logic              op_enable,
   input  logic              op_disable,
   input  logic              op_return,
   input  logic              op_halt,
   input  logic [FLAG_W-1:0] irq_enable,
   input  logic [FLAG_W-1:0] irq_flag,
   output logic              ime,
   output logic              halted,
   output logic              take_irq,
   output logic              pc_hold
);
   if (FLAG_W < 1 || FLAG_W > 32) begin : g_bad_width
      $error("irq_halt_ctrl: FLAG_W must be 1..32");
   end
   if (ENABLE_DELAY > 15) begin : g_bad_delay
      $error("irq_halt_ctrl: ENABLE_DELAY must be 0..15");
   end

   irq_ops_t ops;
   logic     done;
   logic     pending;
   logic     ime_w, halted_w;

   assign ops.en   = op_enable;
   assign ops.dis  = op_disable;
   assign ops.ret  = op_return;
   assign ops.halt = op_halt;

   assign done = insn_done & ~halted_w;

   irq_pend_detect #(.FLAG_W(FLAG_W)) u_pend (
      .mask_i    (irq_enable),
      .flag_i    (irq_flag),
      .pending_o (pending)
   );

   assign take_irq = ime_w & pending & ((done & ~op_disable) | halted_w);

   irq_ime_unit #(.ENABLE_DELAY(ENABLE_DELAY)) u_ime (
      .clk    (clk),
      .rst_n  (rst_n),
      .done_i (done),
      .ops_i  (ops),
      .take_i (take_irq),
      .ime_o  (ime_w)
   );

   irq_halt_unit u_halt (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (done),
      .ops_i     (ops),
      .ime_i     (ime_w),
      .pending_i (pending),
      .take_i    (take_irq),
      .halted_o  (halted_w),
      .pc_hold_o (pc_hold)
   );

   assign ime    = ime_w;
   assign halted = halted_w;

   // R6: a service request needs a pending source and no disable at the boundary
   a_r6_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> (pending && !(done && op_disable)));
   // R11: masked flags alone never request service
   a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_enable & irq_flag) == '0) |-> !take_irq);
   // R1: outputs at rest right after reset
   a_r1_reset: assert property (@(posedge clk)
      !rst_n |=> (!ime && !halted && !pc_hold));
   a_ops_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      insn_done |-> $onehot0({op_enable, op_disable, op_return, op_halt}));
endmodule

// File: tb/sim_irq_halt_ctrl.sv
module sim_irq_halt_ctrl;
   localparam int W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic insn_done = 0, op_enable = 0, op_disable = 0, op_return = 0, op_halt = 0;
   logic [W-1:0] irq_enable = '0, irq_flag = '0;
   logic ime, halted, take_irq, pc_hold;

   int n_chk = 0;
   int n_bad = 0;
   logic seen_take;

   always #4 clk = ~clk;

   irq_halt_ctrl #(.FLAG_W(W), .ENABLE_DELAY(1)) u0 (
      .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .op_enable(op_enable),
      .op_disable(op_disable), .op_return(op_return), .op_halt(op_halt),
      .irq_enable(irq_enable), .irq_flag(irq_flag), .ime(ime), .halted(halted),
      .take_irq(take_irq), .pc_hold(pc_hold));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   // one cycle with the given strobes; take_irq sampled mid-cycle
   task automatic issue(input logic d, input logic en, input logic dis,
                        input logic ret, input logic hlt);
      insn_done = d; op_enable = en; op_disable = dis; op_return = ret; op_halt = hlt;
      #1 seen_take = take_irq;
      @(negedge clk);
      insn_done = 0; op_enable = 0; op_disable = 0; op_return = 0; op_halt = 0;
   endtask

   task automatic nop();          issue(1, 0, 0, 0, 0); endtask
   task automatic idle();         issue(0, 0, 0, 0, 0); endtask

   task automatic t_reset();
      chk("R1 ime", ime, 0);
      chk("R1 halted", halted, 0);
      chk("R1 pc_hold", pc_hold, 0);
      chk("R1 take_irq", take_irq, 0);
      nop();
      chk("R1 no delayed enable", ime, 0);
   endtask

   task automatic t_ret_dis();
      issue(1, 0, 0, 1, 0);
      chk("R5 ime after return", ime, 1);
      irq_enable = 5'b00100; irq_flag = 5'b00100;
      issue(1, 0, 1, 0, 0);
      chk("R2 no take on disable", seen_take, 0);
      chk("R2 ime after disable", ime, 0);
      irq_enable = '0; irq_flag = '0;
   endtask

   task automatic t_enable_delay();
      issue(1, 1, 0, 0, 0);
      chk("R3 ime after enable", ime, 0);
      nop();
      chk("R3 ime after next insn", ime, 1);
      issue(1, 0, 1, 0, 0);
      chk("R2 ime cleared", ime, 0);
   endtask

   task automatic t_enable_cancel();
      issue(1, 1, 0, 0, 0);
      issue(1, 0, 1, 0, 0);
      chk("R4 ime after cancel", ime, 0);
      nop();
      nop();
      chk("R4 enable stays cancelled", ime, 0);
   endtask

   task automatic t_ignore_undone();
      issue(0, 1, 0, 0, 0);
      nop();
      nop();
      chk("R10 enable without done ignored", ime, 0);
      issue(0, 0, 0, 1, 0);
      chk("R10 return without done ignored", ime, 0);
      issue(0, 0, 0, 0, 1);
      chk("R10 halt without done ignored", halted, 0);
   endtask

   task automatic t_take();
      issue(1, 0, 0, 1, 0);
      irq_enable = 5'b00001; irq_flag = 5'b00010;
      nop();
      chk("R11 masked flag no take", seen_take, 0);
      chk("R11 ime kept", ime, 1);
      irq_flag = 5'b00011;
      nop();
      chk("R6 take at boundary", seen_take, 1);
      chk("R6 ime cleared by take", ime, 0);
      irq_enable = '0; irq_flag = '0;
   endtask

   task automatic t_halt_ime();
      issue(1, 0, 0, 1, 0);
      issue(1, 0, 0, 0, 1);
      chk("R7 halted", halted, 1);
      irq_enable = 5'b10000; irq_flag = 5'b01111;
      idle(); idle();
      chk("R11 masked flags keep sleep", halted, 1);
      chk("R7 no take while asleep", seen_take, 0);
      irq_flag = 5'b10000;
      #1 chk("R7 take on wake", take_irq, 1);
      @(negedge clk);
      chk("R7 awake", halted, 0);
      chk("R7 ime cleared", ime, 0);
      irq_enable = '0; irq_flag = '0;
   endtask

   task automatic t_halt_noime();
      issue(1, 0, 0, 0, 1);
      chk("R8 halted", halted, 1);
      issue(1, 0, 0, 1, 0);
      chk("R10 done ignored while halted", ime, 0);
      chk("R10 still halted", halted, 1);
      irq_enable = 5'b00010; irq_flag = 5'b00010;
      #1 chk("R8 no take on wake", take_irq, 0);
      @(negedge clk);
      chk("R8 awake", halted, 0);
      irq_enable = '0; irq_flag = '0;
   endtask

   task automatic t_halt_bug();
      irq_enable = 5'b01000; irq_flag = 5'b01000;
      issue(1, 0, 0, 0, 1);
      chk("R9 not halted", halted, 0);
      chk("R9 hold raised", pc_hold, 1);
      idle();
      chk("R9 hold kept", pc_hold, 1);
      nop();
      chk("R9 hold released", pc_hold, 0);
      irq_enable = '0; irq_flag = '0;
   endtask

   initial begin : watchdog
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ret_dis();
      t_enable_delay();
      t_enable_cancel();
      t_ignore_undone();
      t_take();
      t_halt_ime();
      t_halt_noime();
      t_halt_bug();
      idle();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule